// File: doc/BRIEF.md
# Banked GPIO Controller with Aggregated Interrupt

The controller serves 70 general-purpose pins through a 32-bit register port. Every per-pin feature is stored as a group of 32-bit bank registers placed 4 bytes apart: output enable, pin data, interrupt enable, interrupt polarity, interrupt type and interrupt status. Bank k of a feature holds pins 32k to 32k+31, so the last bank of each feature holds only six pins.

Each pin's input first passes through a two-flop synchroniser. The synchronised level feeds the data read-back and the trigger logic. The type and polarity bits of a pin select one of four triggers: high level, low level, rising edge or falling edge. When its trigger fires, the pin's status bit is set. Software clears the bit by writing a one to it. A single interrupt line is raised while any pin has both its status bit and its enable bit set.

Writes take effect on the clock edge where `wr_en` is high. A read is requested with `rd_en`, and `rd_data` presents the value from the clock edge where `rd_en` was sampled. `rd_data` holds that value until the next read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n sits at bit (n mod 32) of the register at feature base + 4*(n div 32). The feature bases are: output enable 0x014, pin data 0x024, interrupt enable 0x044, polarity 0x104, type 0x114, status 0x124. Read data appears on `rd_data` after the edge that samples `rd_en`.
- R2: After reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R3: A write to an output-enable or data bank register sets the matching bits of `pin_oe` or `pin_out` from the next edge on. With no such write, those outputs stay unchanged.
- R4: A read of a data bank register returns the levels of `pin_in` after two synchronising flops. It does not return the driven data.
- R5: Type bit 0 selects level triggering. Polarity 0 sets status while the synchronised input is high, and polarity 1 sets it while the input is low.
- R6: Type bit 1 selects edge triggering. Polarity 0 sets status on a rising edge of the synchronised input, and polarity 1 on a falling edge. The opposite edge does not set status.
- R7: An edge-triggered status bit stays set until a one is written to it in the status register. Writing zero to it leaves it set.
- R8: A level-triggered status bit that is cleared while its active level is still present reads back as set.
- R9: Status bits are set whatever the enable bits are. `irq` is high exactly while some pin has both its status bit and its enable bit set.
- R10: The unused upper 26 bits of each third bank register read zero and ignore writes. Addresses that match no bank register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one edge after the read strobe |
| pin_in | input | 70 | Raw pin input levels |
| pin_oe | output | 70 | Per-pin output drive enable |
| pin_out | output | 70 | Per-pin output data |
| irq | output | 1 | Aggregated interrupt |

## Verification
The hardest cases to reach are the ones where a trigger and a clear meet. Examples are a clear written while a level source is still active, and a polarity or type change made while the pin is steady. Reaching them needs the right register order and timing. The bench writes the type bit before the polarity bit, so a falling-edge pin never passes through an active-low level setting. It also holds a level pin high across its write-one clear, so status sets again in the same edge. The enable is left off while a level pin is pending, which shows that status collects independently of `irq`.

// File: rtl/gpio_bank_ctrl_pkg.sv
package gpio_bank_ctrl_pkg;

  localparam int REG_W    = 32;
  localparam int ADDR_W   = 12;
  localparam int NUM_FEAT = 6;

  // feature indices; the bank registers of each feature sit 4 bytes apart
  localparam int FT_OE   = 0;
  localparam int FT_DOUT = 1;
  localparam int FT_IEN  = 2;
  localparam int FT_POL  = 3;
  localparam int FT_TYP  = 4;
  localparam int FT_STAT = 5;

  localparam logic [ADDR_W-1:0] FEAT_BASE [NUM_FEAT] = '{
    12'h014, 12'h024, 12'h044, 12'h104, 12'h114, 12'h124
  };

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/gpio_bank_reg.sv
module gpio_bank_reg #(
  parameter int NUM_PINS  = 70,
  parameter int REG_W     = 32,
  parameter int NUM_BANKS = (NUM_PINS + REG_W - 1) / REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_we,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NUM_PINS-1:0]  q
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int LO = g * REG_W;
    localparam int BW = (NUM_PINS - LO > REG_W) ? REG_W : NUM_PINS - LO;

    logic          bank_ce;
    logic [BW-1:0] slice_q;
    logic [BW-1:0] slice_nxt;

    assign bank_ce = bank_we[g];

    always_comb begin
      slice_nxt = slice_q;
      if (bank_ce) slice_nxt = wr_data[BW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slice_q <= '0;
      else        slice_q <= slice_nxt;
    end

    assign q[LO +: BW] = slice_q;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 70
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] typ,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] status
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] act_now;
  logic [NUM_PINS-1:0] act_prev;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] stat_q;
  logic [NUM_PINS-1:0] stat_nxt;

  // polarity folds both senses onto "active high"
  assign act_now  = lvl ^ pol;
  assign act_prev = prev_q ^ pol;

  always_comb begin
    evt      = (~typ & act_now) | (typ & act_now & ~act_prev);
    // a trigger in the same cycle as a clear wins, so no event is lost
    stat_nxt = (stat_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_nxt;
    end
  end

  assign status = stat_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~clr) != '0) |=> ((($past(stat_q) & ~$past(clr)) & ~stat_q) == '0)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((stat_q & $past(clr & ~evt)) == '0)); // R7

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~typ & (lvl ^ pol)) != '0) |=> (($past(~typ & (lvl ^ pol)) & ~stat_q) == '0)); // R8

  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((stat_q & ~$past(stat_q)) == '0)); // R6

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 70
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int PAD_W     = NUM_BANKS * REG_W;

  logic [NUM_FEAT-1:0][NUM_BANKS-1:0] addr_hit;
  logic [NUM_PINS-1:0]                feat_q [NUM_FEAT];
  logic [NUM_PINS-1:0]                pin_lvl;
  logic [NUM_PINS-1:0]                stat_clr;
  logic [NUM_FEAT-1:0][PAD_W-1:0]     rd_src;
  logic [REG_W-1:0]                   rd_nxt;
  logic [REG_W-1:0]                   rd_q;
  logic                               rd_hit;

  // address decode: one comparator per feature bank register
  for (genvar f = 0; f < NUM_FEAT; f++) begin : g_dec_f
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec_b
      localparam logic [ADDR_W-1:0] BANK_ADDR = FEAT_BASE[f] + ADDR_W'(4 * b);
      assign addr_hit[f][b] = (addr == BANK_ADDR);
    end
  end

  // configuration storage for every feature except status
  for (genvar f = 0; f < FT_STAT; f++) begin : g_cfg
    gpio_bank_reg #(
      .NUM_PINS (NUM_PINS),
      .REG_W    (REG_W),
      .NUM_BANKS(NUM_BANKS)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .bank_we(addr_hit[f] & {NUM_BANKS{wr_en}}),
      .wr_data(wr_data),
      .q      (feat_q[f])
    );
  end

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_lvl)
  );

  // write-one-to-clear mask, one slice per bank
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_clr
    localparam int LO = g * REG_W;
    localparam int BW = (NUM_PINS - LO > REG_W) ? REG_W : NUM_PINS - LO;
    assign stat_clr[LO +: BW] = (wr_en && addr_hit[FT_STAT][g]) ? wr_data[BW-1:0] : '0;
  end

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (pin_lvl),
    .pol   (feat_q[FT_POL]),
    .typ   (feat_q[FT_TYP]),
    .clr   (stat_clr),
    .status(feat_q[FT_STAT])
  );

  // read path: data feature returns the synchronised pin level
  always_comb begin
    for (int f = 0; f < NUM_FEAT; f++) begin
      rd_src[f] = '0;
      if (f == FT_DOUT) rd_src[f][NUM_PINS-1:0] = pin_lvl;
      else              rd_src[f][NUM_PINS-1:0] = feat_q[f];
    end
  end

  always_comb begin
    rd_nxt = '0;
    rd_hit = 1'b0;
    for (int f = 0; f < NUM_FEAT; f++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addr_hit[f][b]) begin
          rd_nxt = rd_src[f][b*REG_W +: REG_W];
          rd_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;
  assign pin_oe  = feat_q[FT_OE];
  assign pin_out = feat_q[FT_DOUT];
  assign irq     = |(feat_q[FT_STAT] & feat_q[FT_IEN]);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == '0)); // R10

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr_hit[FT_OE] != '0)) |=> $stable(pin_oe)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (feat_q[FT_IEN] != '0)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq && pin_oe == '0 && pin_out == '0)); // R2

endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [69:0] pin_in = '0;
  logic [69:0] pin_oe;
  logic [69:0] pin_out;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wdata), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {38'd0, rd_data}, {38'd0, e});
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R2 reset state
    check("R2 irq", {69'd0, irq}, 70'd0);
    check("R2 pin_oe", pin_oe, 70'd0);
    check("R2 pin_out", pin_out, 70'd0);
    for (int f = 0; f < 6; f++) begin
      for (int b = 0; b < 3; b++) begin
        logic [11:0] base;
        case (f)
          0: base = 12'h014; 1: base = 12'h024; 2: base = 12'h044;
          3: base = 12'h104; 4: base = 12'h114; default: base = 12'h124;
        endcase
        rd(base + 12'(4 * b), 32'h0, "R2 reset register");
      end
    end

    // R3 / R1 / R10 output enable and data banks
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h024, 32'hA5A5_0001);
    rd(12'h018, 32'hFFFF_FFFF, "R1 oe bank1 readback");
    rd(12'h01C, 32'h0000_003F, "R10 oe bank2 upper bits");
    check("R3 pin_oe", pin_oe, {6'h3F, 32'hFFFF_FFFF, 32'h0});
    check("R3 pin_out", pin_out, {38'd0, 32'hA5A5_0001});

    // R10 unmapped addresses and ignored writes
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0, "R10 unmapped bank3");
    rd(12'h200, 32'h0, "R10 unmapped high");
    rd(12'h016, 32'h0, "R10 misaligned");
    rd(12'h014, 32'h0, "R10 oe bank0 untouched");
    check("R3 pin_oe after stray writes", pin_oe, {6'h3F, 32'hFFFF_FFFF, 32'h0});

    // R4 synchronised pin levels
    @(negedge clk);
    pin_in = {6'h2A, 32'hC3C3_0F0F, 32'h1234_ABCD};
    idle(4);
    rd(12'h024, 32'h1234_ABCD, "R4 data bank0");
    rd(12'h028, 32'hC3C3_0F0F, "R4 data bank1");
    rd(12'h02C, 32'h0000_002A, "R4 data bank2");
    @(negedge clk);
    pin_in = '0;
    idle(4);
    wr(12'h124, 32'hFFFF_FFFF);
    wr(12'h128, 32'hFFFF_FFFF);
    wr(12'h12C, 32'hFFFF_FFFF);
    rd(12'h124, 32'h0, "R7 status cleared bank0");
    rd(12'h12C, 32'h0, "R7 status cleared bank2");

    // R6 rising edge on pin 3, R7 sticky and write-one clear
    wr(12'h114, 32'h0000_0008);
    wr(12'h044, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    idle(4);
    check("R9 irq on rising", {69'd0, irq}, 70'd1);
    rd(12'h124, 32'h0000_0008, "R6 rising status");
    @(negedge clk); pin_in[3] = 1'b0;
    idle(4);
    rd(12'h124, 32'h0000_0008, "R7 sticky after fall");
    wr(12'h124, 32'h0);
    rd(12'h124, 32'h0000_0008, "R7 write zero ignored");
    wr(12'h124, 32'h0000_0008);
    rd(12'h124, 32'h0, "R7 write one clears");
    check("R9 irq after clear", {69'd0, irq}, 70'd0);

    // R6 falling edge on pin 40 (bank1 bit 8): type before polarity
    wr(12'h118, 32'h0000_0100);
    wr(12'h108, 32'h0000_0100);
    wr(12'h048, 32'h0000_0100);
    @(negedge clk); pin_in[40] = 1'b1;
    idle(4);
    rd(12'h128, 32'h0, "R6 rising ignored in falling mode");
    check("R6 no irq on rising", {69'd0, irq}, 70'd0);
    @(negedge clk); pin_in[40] = 1'b0;
    idle(4);
    rd(12'h128, 32'h0000_0100, "R6 falling status");
    check("R9 irq on falling", {69'd0, irq}, 70'd1);
    wr(12'h128, 32'h0000_0100);
    rd(12'h128, 32'h0, "R7 falling clear");

    // R5 high level on pin 69 (bank2 bit 5), R9 gating, R8 re-set
    @(negedge clk); pin_in[69] = 1'b1;
    idle(4);
    rd(12'h12C, 32'h0000_0020, "R5 level high status");
    check("R9 no irq while disabled", {69'd0, irq}, 70'd0);
    wr(12'h04C, 32'h0000_0020);
    idle(1);
    check("R9 irq once enabled", {69'd0, irq}, 70'd1);
    wr(12'h12C, 32'h0000_0020);
    rd(12'h12C, 32'h0000_0020, "R8 level re-sets after clear");
    @(negedge clk); pin_in[69] = 1'b0;
    idle(4);
    wr(12'h12C, 32'h0000_0020);
    rd(12'h12C, 32'h0, "R8 clear after level drops");
    check("R9 irq low at end", {69'd0, irq}, 70'd0);

    // R5 low level on pin 0
    wr(12'h104, 32'h0000_0001);
    idle(3);
    rd(12'h124, 32'h0000_0001, "R5 level low status");
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    wr(12'h124, 32'h0000_0001);
    rd(12'h124, 32'h0, "R5 low level released");

    idle(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 pending reads actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule